// File: doc/BRIEF.md
# Accumulator Arithmetic and Flag Unit

This block is the combinational arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it takes an operation code, two operand bytes and the current carry (C), overflow (OV) and auxiliary-carry (AC) flags. From these it produces a primary result byte, a secondary result byte and the next value of each flag. Each flag also gets a write strobe, so the surrounding core can tell which flags the operation owns.

The flag rules follow the classic accumulator semantics. The three add/subtract forms write all three flags. Multiply and divide clear C and report OV. Decimal adjust touches only C, and it can set C but never clear it. Rotates through carry and the single-bit carry operations touch only C. Increment, decrement and the byte logic operations leave every flag alone.

Inside, a small decoder turns the operation code into a bundle of strobes. The datapath acts on those strobes. Decode of instructions, the register file and memory are outside the block.

Top module: `acc_alu`

## Requirements
- R1: ADD (code 0) gives {cOut,resA} = opA + opB. ADDC (code 1) also adds cIn. AC is the carry out of bit 3. OV is set when the signed 8-bit sum overflows. cWe, ovWe and acWe are all 1.
- R2: SUBB (code 2) gives resA = opA - opB - cIn modulo 256. C is the borrow out of bit 7 and AC is the borrow out of bit 3. OV is set when the signed difference overflows. All three write strobes are 1.
- R3: INC (code 3) gives opA + 1 and DEC (code 4) gives opA - 1, both wrapping modulo 256. All write strobes are 0.
- R4: AND (code 5), OR (code 6) and XOR (code 7) give the bitwise result of opA and opB. All write strobes are 0.
- R5: MUL (code 8) gives the 16-bit product opA*opB, with the high byte on resB and the low byte on resA. C is forced to 0, and OV is 1 exactly when the product exceeds 255. cWe and ovWe are 1 and acWe is 0.
- R6: DIV (code 9) with opB nonzero gives the quotient on resA and the remainder on resB, with OV = 0. With opB zero, OV = 1 and both result bytes are unspecified. In both cases C is forced to 0, cWe and ovWe are 1, and acWe is 0.
- R7: DA (code 10) works in two steps. First it adds 0x06 if opA[3:0] > 9 or acIn is set. It then adds 0x60 if the high nibble of that intermediate value exceeds 9, cIn is set, or the first step carried. C becomes cIn OR any carry out, so C is never cleared. Only cWe is 1.
- R8: RLC (code 11) gives {opA[6:0],cIn} with C = opA[7]. RRC (code 12) gives {cIn,opA[7:1]} with C = opA[0]. Only cWe is 1.
- R9: CLRC (code 13) makes C = 0, SETC (code 14) makes C = 1, and CPLC (code 15) makes C = ~cIn. Only cWe is 1 and resA = opA.
- R10: The bit operand is opB[0]. The operations and their C results are: ANDC (16) gives cIn & bit, ANDNC (17) gives cIn & ~bit, ORC (18) gives cIn | bit, ORNC (19) gives cIn | ~bit, and MOVC (20) gives bit. Only cWe is 1 and resA = opA.
- R11: A flag output whose write strobe is 0 equals the matching flag input. resB equals opB for every operation other than MUL and DIV.
- R12: Codes 21 to 31 are unused. They pass opA to resA, raise no write strobe and leave every flag output equal to its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aluOp | input | 5 | Operation code |
| opA | input | 8 | Accumulator operand |
| opB | input | 8 | Second operand; bit 0 is the bit operand |
| cIn | input | 1 | Current carry flag |
| ovIn | input | 1 | Current overflow flag |
| acIn | input | 1 | Current auxiliary-carry flag |
| resA | output | 8 | Primary result byte |
| resB | output | 8 | Secondary result byte |
| cOut | output | 1 | Next carry flag |
| ovOut | output | 1 | Next overflow flag |
| acOut | output | 1 | Next auxiliary-carry flag |
| cWe | output | 1 | Carry write strobe |
| ovWe | output | 1 | Overflow write strobe |
| acWe | output | 1 | Auxiliary-carry write strobe |

## Verification
Some properties are checked whenever the inputs settle:
- the plain add sum and the borrowing difference
- the product and the division identity with a nonzero divisor
- the strobe pattern of the flag-neutral operations
- decimal adjust never dropping an incoming carry
- flag outputs echoing their inputs while their strobe is low

Some behaviour shows only through the bench's scenarios, because the properties do not pin down the exact bit-level values:
- the half-carry and signed-overflow values at the nibble and sign boundaries
- the exact decimal-adjust corrections
- both rotate directions
- each single-bit carry operation with both bit values
- the divide-by-zero overflow
- the unused codes

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int PROD_W = 2 * DATA_W;
  localparam int OP_W   = 5;
  localparam int BCD_MAX = 9;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUBB  = 5'd2,
    OP_INC   = 5'd3,
    OP_DEC   = 5'd4,
    OP_AND   = 5'd5,
    OP_OR    = 5'd6,
    OP_XOR   = 5'd7,
    OP_MUL   = 5'd8,
    OP_DIV   = 5'd9,
    OP_DA    = 5'd10,
    OP_RLC   = 5'd11,
    OP_RRC   = 5'd12,
    OP_CLRC  = 5'd13,
    OP_SETC  = 5'd14,
    OP_CPLC  = 5'd15,
    OP_ANDC  = 5'd16,
    OP_ANDNC = 5'd17,
    OP_ORC   = 5'd18,
    OP_ORNC  = 5'd19,
    OP_MOVC  = 5'd20
  } aluOp_e;

  // Which unit drives the primary result byte
  typedef enum logic [2:0] {
    SEL_ADDER,
    SEL_LOGIC,
    SEL_MULT,
    SEL_DIVD,
    SEL_DECADJ,
    SEL_ROT,
    SEL_PASS
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR
  } logicFn_e;

  // Where the next carry comes from
  typedef enum logic [2:0] {
    CF_UNIT,
    CF_ZERO,
    CF_ONE,
    CF_INV,
    CF_AND,
    CF_OR,
    CF_MOV
  } carryFn_e;

  typedef struct packed {
    resSel_e  resSel;
    logicFn_e logicFn;
    carryFn_e carryFn;
    logic     subtract;
    logic     useCin;
    logic     forceOne;
    logic     rotRight;
    logic     invBit;
    logic     wrC;
    logic     wrOv;
    logic     wrAc;
  } aluCtrl_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              subtract,
  output logic [DATA_W-1:0] sum,
  output logic              carryOut,
  output logic              halfOut,
  output logic              ovOut
);

  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   chain;

  // Subtraction as a + ~b + ~borrow; carries then become inverted borrows
  assign bEff     = subtract ? ~b : b;
  assign chain[0] = subtract ? ~cin : cin;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ bEff[i] ^ chain[i];
    assign chain[i+1] = (a[i] & bEff[i]) | (chain[i] & (a[i] ^ bEff[i]));
  end

  assign carryOut = chain[DATA_W] ^ subtract;
  assign halfOut  = chain[NIB_W] ^ subtract;
  assign ovOut    = chain[DATA_W] ^ chain[DATA_W-1];

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [PROD_W-1:0] product,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              divZero
);

  assign product = PROD_W'(a) * PROD_W'(b);
  assign divZero = (b == '0);

  always_comb begin
    if (divZero) begin
      quotient  = '0;
      remainder = '0;
    end else begin
      quotient  = a / b;
      remainder = a % b;
    end
  end

endmodule

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] aluOp,
  output aluCtrl_t        ctrl
);

  aluOp_e opSel;
  assign opSel = aluOp_e'(aluOp);

  always_comb begin
    ctrl          = '0;
    ctrl.resSel   = SEL_PASS;
    ctrl.logicFn  = LG_AND;
    ctrl.carryFn  = CF_UNIT;
    case (opSel)
      OP_ADD, OP_ADDC: begin
        ctrl.resSel = SEL_ADDER;
        ctrl.useCin = (opSel == OP_ADDC);
        ctrl.wrC    = 1'b1;
        ctrl.wrOv   = 1'b1;
        ctrl.wrAc   = 1'b1;
      end
      OP_SUBB: begin
        ctrl.resSel   = SEL_ADDER;
        ctrl.subtract = 1'b1;
        ctrl.useCin   = 1'b1;
        ctrl.wrC      = 1'b1;
        ctrl.wrOv     = 1'b1;
        ctrl.wrAc     = 1'b1;
      end
      OP_INC: begin
        ctrl.resSel   = SEL_ADDER;
        ctrl.forceOne = 1'b1;
      end
      OP_DEC: begin
        ctrl.resSel   = SEL_ADDER;
        ctrl.forceOne = 1'b1;
        ctrl.subtract = 1'b1;
      end
      OP_AND: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicFn = LG_AND;
      end
      OP_OR: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicFn = LG_OR;
      end
      OP_XOR: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicFn = LG_XOR;
      end
      OP_MUL: begin
        ctrl.resSel = SEL_MULT;
        ctrl.wrC    = 1'b1;
        ctrl.wrOv   = 1'b1;
      end
      OP_DIV: begin
        ctrl.resSel = SEL_DIVD;
        ctrl.wrC    = 1'b1;
        ctrl.wrOv   = 1'b1;
      end
      OP_DA: begin
        ctrl.resSel = SEL_DECADJ;
        ctrl.wrC    = 1'b1;
      end
      OP_RLC, OP_RRC: begin
        ctrl.resSel   = SEL_ROT;
        ctrl.rotRight = (opSel == OP_RRC);
        ctrl.wrC      = 1'b1;
      end
      OP_CLRC: begin
        ctrl.carryFn = CF_ZERO;
        ctrl.wrC     = 1'b1;
      end
      OP_SETC: begin
        ctrl.carryFn = CF_ONE;
        ctrl.wrC     = 1'b1;
      end
      OP_CPLC: begin
        ctrl.carryFn = CF_INV;
        ctrl.wrC     = 1'b1;
      end
      OP_ANDC, OP_ANDNC: begin
        ctrl.carryFn = CF_AND;
        ctrl.invBit  = (opSel == OP_ANDNC);
        ctrl.wrC     = 1'b1;
      end
      OP_ORC, OP_ORNC: begin
        ctrl.carryFn = CF_OR;
        ctrl.invBit  = (opSel == OP_ORNC);
        ctrl.wrC     = 1'b1;
      end
      OP_MOVC: begin
        ctrl.carryFn = CF_MOV;
        ctrl.wrC     = 1'b1;
      end
      default: ctrl.resSel = SEL_PASS;
    endcase
  end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
(
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              cIn,
  input  logic              ovIn,
  input  logic              acIn,
  output logic [DATA_W-1:0] resA,
  output logic [DATA_W-1:0] resB,
  output logic              cOut,
  output logic              ovOut,
  output logic              acOut
);

  localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HI_FIX = (DATA_W+1)'(6) << NIB_W;

  // Adder path
  logic [DATA_W-1:0] addB, addSum;
  logic              addCin, addCarry, addHalf, addOv;

  assign addB   = ctrl.forceOne ? DATA_W'(1) : opB;
  assign addCin = ctrl.useCin & cIn;

  acc_alu_adder u_adder (
    .a        (opA),
    .b        (addB),
    .cin      (addCin),
    .subtract (ctrl.subtract),
    .sum      (addSum),
    .carryOut (addCarry),
    .halfOut  (addHalf),
    .ovOut    (addOv)
  );

  // Multiply / divide path
  logic [PROD_W-1:0] product;
  logic [DATA_W-1:0] quotient, remainder;
  logic              divZero;

  acc_alu_muldiv u_muldiv (
    .a         (opA),
    .b         (opB),
    .product   (product),
    .quotient  (quotient),
    .remainder (remainder),
    .divZero   (divZero)
  );

  // Byte logic
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (ctrl.logicFn)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
  end

  // Decimal adjust: two cascaded corrections
  logic              loFix, hiFix, daCarry;
  logic [DATA_W:0]   daLo, daHi;

  assign loFix   = (opA[NIB_W-1:0] > NIB_W'(BCD_MAX)) | acIn;
  assign daLo    = {1'b0, opA} + (loFix ? LO_FIX : '0);
  assign hiFix   = (daLo[DATA_W-1:NIB_W] > NIB_W'(BCD_MAX)) | cIn | daLo[DATA_W];
  assign daHi    = {1'b0, daLo[DATA_W-1:0]} + (hiFix ? HI_FIX : '0);
  assign daCarry = cIn | daLo[DATA_W] | daHi[DATA_W];

  // Rotate through carry
  logic [DATA_W-1:0] rotRes;
  logic              rotCarry;
  assign rotRes   = ctrl.rotRight ? {cIn, opA[DATA_W-1:1]} : {opA[DATA_W-2:0], cIn};
  assign rotCarry = ctrl.rotRight ? opA[0] : opA[DATA_W-1];

  // Result and unit flag selection
  logic unitCarry, unitOv;
  always_comb begin
    resB      = opB;
    unitCarry = 1'b0;
    unitOv    = 1'b0;
    case (ctrl.resSel)
      SEL_ADDER: begin
        resA      = addSum;
        unitCarry = addCarry;
        unitOv    = addOv;
      end
      SEL_LOGIC:  resA = logicRes;
      SEL_MULT: begin
        resA   = product[DATA_W-1:0];
        resB   = product[PROD_W-1:DATA_W];
        unitOv = |product[PROD_W-1:DATA_W];
      end
      SEL_DIVD: begin
        resA   = quotient;
        resB   = remainder;
        unitOv = divZero;
      end
      SEL_DECADJ: begin
        resA      = daHi[DATA_W-1:0];
        unitCarry = daCarry;
      end
      SEL_ROT: begin
        resA      = rotRes;
        unitCarry = rotCarry;
      end
      default:    resA = opA;
    endcase
  end

  // Carry selection for bit operations
  logic bitVal, carrySel;
  assign bitVal = opB[0] ^ ctrl.invBit;

  always_comb begin
    case (ctrl.carryFn)
      CF_ZERO: carrySel = 1'b0;
      CF_ONE:  carrySel = 1'b1;
      CF_INV:  carrySel = ~cIn;
      CF_AND:  carrySel = cIn & bitVal;
      CF_OR:   carrySel = cIn | bitVal;
      CF_MOV:  carrySel = bitVal;
      default: carrySel = unitCarry;
    endcase
  end

  assign cOut  = ctrl.wrC  ? carrySel : cIn;
  assign ovOut = ctrl.wrOv ? unitOv   : ovIn;
  assign acOut = ctrl.wrAc ? addHalf  : acIn;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [4:0] aluOp,
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic       cIn,
  input  logic       ovIn,
  input  logic       acIn,
  output logic [7:0] resA,
  output logic [7:0] resB,
  output logic       cOut,
  output logic       ovOut,
  output logic       acOut,
  output logic       cWe,
  output logic       ovWe,
  output logic       acWe
);

  aluCtrl_t ctrl;

  acc_alu_ctrl u_ctrl (
    .aluOp (aluOp),
    .ctrl  (ctrl)
  );

  acc_alu_datapath u_dp (
    .ctrl  (ctrl),
    .opA   (opA),
    .opB   (opB),
    .cIn   (cIn),
    .ovIn  (ovIn),
    .acIn  (acIn),
    .resA  (resA),
    .resB  (resB),
    .cOut  (cOut),
    .ovOut (ovOut),
    .acOut (acOut)
  );

  assign cWe  = ctrl.wrC;
  assign ovWe = ctrl.wrOv;
  assign acWe = ctrl.wrAc;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker (
  input logic [4:0] aluOp,
  input logic [7:0] opA,
  input logic [7:0] opB,
  input logic       cIn,
  input logic       ovIn,
  input logic       acIn,
  input logic [7:0] resA,
  input logic [7:0] resB,
  input logic       cOut,
  input logic       ovOut,
  input logic       acOut,
  input logic       cWe,
  input logic       ovWe,
  input logic       acWe
);

  logic [8:0]  wideSum;
  logic [7:0]  diffByte;
  logic [15:0] wideProd;
  logic [15:0] divBack;

  assign wideSum  = {1'b0, opA} + {1'b0, opB};
  assign diffByte = opA - opB - {7'd0, cIn};
  assign wideProd = {8'd0, opA} * {8'd0, opB};
  assign divBack  = ({8'd0, resA} * {8'd0, opB}) + {8'd0, resB};

  always_comb begin
    if (aluOp == 5'd0) begin
      AST_ADD_SUM: assert ({cOut, resA} == wideSum && cWe && ovWe && acWe) else $error("add sum"); // R1
    end
    if (aluOp == 5'd2) begin
      AST_SUB_DIFF: assert (resA == diffByte && cWe && ovWe && acWe) else $error("subtract"); // R2
    end
    if (aluOp == 5'd3 || aluOp == 5'd4) begin
      AST_INCDEC_NOFLAG: assert (!cWe && !ovWe && !acWe) else $error("inc/dec strobes"); // R3
    end
    if (aluOp >= 5'd5 && aluOp <= 5'd7) begin
      AST_LOGIC_NOFLAG: assert (!cWe && !ovWe && !acWe) else $error("logic strobes"); // R4
    end
    if (aluOp == 5'd8) begin
      AST_MUL_PRODUCT: assert ({resB, resA} == wideProd && !cOut && ovOut == (wideProd > 16'd255)) else $error("mul"); // R5
    end
    if (aluOp == 5'd9 && opB != 8'd0) begin
      AST_DIV_IDENTITY: assert (divBack == {8'd0, opA} && resB < opB && !ovOut && !cOut) else $error("div"); // R6
    end
    if (aluOp == 5'd10 && cIn) begin
      AST_DA_STICKY: assert (cOut) else $error("da carry dropped"); // R7
    end
    if (!cWe) begin
      AST_C_HOLD: assert (cOut == cIn) else $error("c hold"); // R11
    end
    if (!ovWe) begin
      AST_OV_HOLD: assert (ovOut == ovIn) else $error("ov hold"); // R11
    end
    if (!acWe) begin
      AST_AC_HOLD: assert (acOut == acIn) else $error("ac hold"); // R11
    end
  end

endmodule

bind acc_alu acc_alu_checker u_chk (.*);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] aluOp = '0;
  logic [7:0] opA = '0, opB = '0;
  logic       cIn = 1'b0, ovIn = 1'b0, acIn = 1'b0;
  logic [7:0] resA, resB;
  logic       cOut, ovOut, acOut, cWe, ovWe, acWe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  acc_alu dut (.*);

  typedef struct {
    string req;
    int    op;
    int    res;
    int    resHi;
    bit    chkRes;
    bit    c, ov, ac;
    bit    wc, wov, wac;
  } exp_t;

  exp_t sbQ[$];

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic exp_t model(int op, int a, int b, bit c, bit ov, bit ac);
    exp_t e;
    int s, t;
    e.op = op; e.res = a; e.resHi = b; e.chkRes = 1;
    e.c = c; e.ov = ov; e.ac = ac; e.wc = 0; e.wov = 0; e.wac = 0;
    e.req = "R12";
    case (op)
      0, 1: begin
        t = (op == 1) ? int'(c) : 0;
        s = a + b + t;
        e.res = s & 255; e.c = (s > 255);
        e.ac = ((a & 15) + (b & 15) + t) > 15;
        s = sgn(a) + sgn(b) + t;
        e.ov = (s > 127) || (s < -128);
        e.wc = 1; e.wov = 1; e.wac = 1; e.req = "R1";
      end
      2: begin
        s = a - b - int'(c);
        e.res = s & 255; e.c = (s < 0);
        e.ac = ((a & 15) - (b & 15) - int'(c)) < 0;
        s = sgn(a) - sgn(b) - int'(c);
        e.ov = (s > 127) || (s < -128);
        e.wc = 1; e.wov = 1; e.wac = 1; e.req = "R2";
      end
      3: begin e.res = (a + 1) & 255; e.req = "R3"; end
      4: begin e.res = (a + 255) & 255; e.req = "R3"; end
      5: begin e.res = a & b; e.req = "R4"; end
      6: begin e.res = a | b; e.req = "R4"; end
      7: begin e.res = a ^ b; e.req = "R4"; end
      8: begin
        s = a * b;
        e.res = s & 255; e.resHi = s / 256;
        e.c = 0; e.ov = (s > 255); e.wc = 1; e.wov = 1; e.req = "R5";
      end
      9: begin
        e.c = 0; e.wc = 1; e.wov = 1; e.req = "R6";
        if (b == 0) begin e.ov = 1; e.chkRes = 0; end
        else begin e.res = a / b; e.resHi = a % b; e.ov = 0; end
      end
      10: begin
        s = a;
        if ((a & 15) > 9 || ac) s = s + 6;
        if (((s / 16) % 16) > 9 || c || s > 255) s = s + 96;
        e.res = s & 255; e.c = c || (s > 255); e.wc = 1; e.req = "R7";
      end
      11: begin e.res = ((a * 2) + int'(c)) & 255; e.c = (a >= 128); e.wc = 1; e.req = "R8"; end
      12: begin e.res = (int'(c) * 128) + (a / 2); e.c = a[0]; e.wc = 1; e.req = "R8"; end
      13: begin e.c = 0; e.wc = 1; e.req = "R9"; end
      14: begin e.c = 1; e.wc = 1; e.req = "R9"; end
      15: begin e.c = !c; e.wc = 1; e.req = "R9"; end
      16: begin e.c = c && b[0]; e.wc = 1; e.req = "R10"; end
      17: begin e.c = c && !b[0]; e.wc = 1; e.req = "R10"; end
      18: begin e.c = c || b[0]; e.wc = 1; e.req = "R10"; end
      19: begin e.c = c || !b[0]; e.wc = 1; e.req = "R10"; end
      20: begin e.c = b[0]; e.wc = 1; e.req = "R10"; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(int op, int a, int b, bit c, bit ov, bit ac);
    @(posedge clk);
    aluOp = 5'(op); opA = 8'(a); opB = 8'(b);
    cIn = c; ovIn = ov; acIn = ac;
    sbQ.push_back(model(op, a, b, c, ov, ac));
  endtask

  // Monitor: compares settled outputs at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        exp_t e;
        e = sbQ.pop_front();
        if (e.chkRes) begin
          check(e.req, "resA", int'(resA), e.res);
          check(e.req, "resB", int'(resB), e.resHi);
        end
        check(e.req, "cOut", int'(cOut), int'(e.c));
        check(e.req, "ovOut", int'(ovOut), int'(e.ov));
        check(e.req, "acOut", int'(acOut), int'(e.ac));
        check(e.req, "we", int'({cWe, ovWe, acWe}), int'({e.wc, e.wov, e.wac}));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog cycles actual=150000 expected<150000");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // reset/idle state: zeros through ADD (R1)
    drive(0, 0, 0, 0, 0, 0);
    // R1 corners
    drive(0, 8'hFF, 8'h01, 0, 0, 0);
    drive(0, 8'h7F, 8'h01, 0, 0, 0);
    drive(0, 8'h80, 8'h80, 0, 1, 1);
    drive(1, 8'h0F, 8'h00, 1, 0, 0);
    drive(1, 8'hFE, 8'h01, 1, 0, 0);
    // R2 corners
    drive(2, 8'h80, 8'h01, 0, 0, 0);
    drive(2, 8'h00, 8'h00, 1, 0, 0);
    drive(2, 8'h10, 8'h01, 0, 1, 1);
    // R3 wrap with flags held
    drive(3, 8'hFF, 8'h00, 1, 1, 1);
    drive(4, 8'h00, 8'h00, 0, 1, 0);
    // R4
    drive(5, 8'hF0, 8'h3C, 1, 0, 1);
    drive(6, 8'hF0, 8'h0C, 0, 1, 0);
    drive(7, 8'hAA, 8'hFF, 1, 1, 1);
    // R5
    drive(8, 8'h10, 8'h10, 1, 0, 1);
    drive(8, 8'h0F, 8'h11, 1, 1, 0);
    drive(8, 8'hFF, 8'hFF, 0, 0, 0);
    // R6
    drive(9, 8'hFB, 8'h12, 1, 1, 0);
    drive(9, 8'h42, 8'h00, 1, 0, 0);
    drive(9, 8'h05, 8'h09, 0, 1, 1);
    // R7
    drive(7, 0, 0, 0, 0, 0);
    drive(10, 8'h9A, 8'h00, 0, 0, 0);
    drive(10, 8'h15, 8'h00, 1, 0, 0);
    drive(10, 8'h08, 8'h00, 0, 0, 1);
    drive(10, 8'h99, 8'h00, 0, 0, 0);
    drive(10, 8'hA0, 8'h00, 0, 0, 1);
    // R8
    drive(11, 8'h81, 8'h00, 0, 0, 0);
    drive(11, 8'h01, 8'h00, 1, 0, 0);
    drive(12, 8'h01, 8'h00, 0, 0, 0);
    drive(12, 8'h80, 8'h00, 1, 1, 1);
    // R9, R10 with both carry and bit values
    for (int op = 13; op <= 20; op++)
      for (int k = 0; k < 4; k++)
        drive(op, 8'h5A, k >> 1, k[0], 1, 0);
    // R12 unused codes
    drive(21, 8'h33, 8'h44, 1, 0, 1);
    drive(31, 8'hC3, 8'h00, 0, 1, 0);
    // R11 sweep over every code
    for (int op = 0; op < 32; op++)
      for (int n = 0; n < 120; n++)
        drive(op, $urandom_range(255), $urandom_range(255),
              1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)));
    while (sbQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule